// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block watches one port of a shared-media repeater and cuts the port's received traffic off from the segment when the port misbehaves. There are two ways to trip it. One is a run of carrier events that each contain a collision. The other is a single collision that stays asserted for too long. While the port is cut off, the block keeps watching it, and repeated traffic is still sent to the port. Only what the port receives is held back, and the repeater does that by gating on `part_o`.

The port is reconnected once it shows a stretch of clean activity, measured in bit times through the `bit_tick` strobe. The `alt_sel` input chooses which activity counts toward that stretch. By default both receive and transmit activity count. When `alt_sel` is high, only transmit activity counts. Each time the port becomes isolated, `part_evt_o` gives a single-cycle pulse that feeds an external statistics counter.

A carrier event is one continuous interval during which any of `rx_act`, `tx_act` or `coll` is high. Reset is synchronous and active high.

Top module: `rptr_autopart`

## Requirements
- R1: After reset, `part_o` and `part_evt_o` are both 0, and all internal counts and timers start from zero.
- R2: When connected, the port becomes isolated when the (COLL_LIMIT+1)-th consecutive colliding carrier event ends. `part_o` is 1 after the clock edge at which the carrier falls.
- R3: A carrier event that ends without any collision resets the consecutive-collision streak to zero. The streak count saturates and does not wrap.
- R4: If `coll` is sampled high on LONG_COLL_CYC consecutive clock edges, the port becomes isolated at the last of those edges. A shorter collision does not isolate the port.
- R5: `part_evt_o` is 1 for exactly one cycle, in the first cycle of each isolation. It stays 0 while the port is already isolated, whatever happens on the inputs, and it stays 0 when the port reconnects.
- R6: With `alt_sel`=0, an isolated port reconnects at the edge where the RECON_BT-th `bit_tick` is sampled with (`rx_act` or `tx_act`) high and `coll` low. Cycles without `bit_tick` do not advance the window.
- R7: With `alt_sel`=1, only `tx_act` qualifies for the reconnection window. Receive-only activity never reconnects the port.
- R8: The reconnection window restarts from zero on any cycle with `coll` high, and on any cycle without qualifying activity.
- R9: Reconnection clears the consecutive-collision streak. After reconnecting, a fresh run of COLL_LIMIT+1 colliding events is needed to isolate the port again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_act | input | 1 | Port is receiving (carrier from the port) |
| tx_act | input | 1 | Repeater is transmitting to the port |
| coll | input | 1 | Collision involving this port |
| bit_tick | input | 1 | One strobe per bit time |
| alt_sel | input | 1 | 1 = only transmit activity counts toward reconnection |
| part_o | output | 1 | Port is isolated |
| part_evt_o | output | 1 | One-cycle pulse on each entry into isolation |

## Verification
The hardest situation to reach from the ports is whether the streak is cleared at reconnection. Once the port is isolated, the clean packet that reconnects it normally ends cleanly and zeroes the streak anyway, which hides a missing clear. The bench therefore lets the reconnecting packet run on past the reconnection edge and adds a collision before it ends. The port must then stay connected until COLL_LIMIT further colliding events have followed. The window restart is also exercised: a collision or a gap is placed one tick short of the threshold, and the bench checks that exactly RECON_BT further ticks are needed.

// File: rtl/rptr_part_pkg.sv
package rptr_part_pkg;

   typedef enum logic {
      PS_CONNECTED = 1'b0,
      PS_ISOLATED  = 1'b1
   } part_state_e;

   typedef struct packed {
      logic rx;
      logic tx;
      logic coll;
   } port_act_t;

endpackage

// File: rtl/rptr_coll_streak.sv
// Counts consecutive carrier events that contain a collision.
module rptr_coll_streak #(
   parameter int COLL_LIMIT = 60
) (
   input  logic clk,
   input  logic rst,
   input  logic carrier_i,
   input  logic coll_i,
   input  logic clr_i,
   output logic trip_o
);
   localparam int SW = $clog2(COLL_LIMIT + 2);
   localparam logic [SW-1:0] SMAX  = '1;
   localparam logic [SW-1:0] SLIM  = SW'(COLL_LIMIT);

   logic          carrier_q;
   logic          seen_q;
   logic [SW-1:0] cnt_q;
   logic          evt_end;

   assign evt_end = carrier_q & ~carrier_i;
   assign trip_o  = evt_end & seen_q & (cnt_q >= SLIM);

   always_ff @(posedge clk) begin
      if (rst) begin
         carrier_q <= 1'b0;
         seen_q    <= 1'b0;
         cnt_q     <= '0;
      end else begin
         carrier_q <= carrier_i;
         if (evt_end)
            seen_q <= 1'b0;
         else if (coll_i)
            seen_q <= 1'b1;
         if (clr_i)
            cnt_q <= '0;
         else if (evt_end)
            cnt_q <= seen_q ? ((cnt_q == SMAX) ? SMAX : cnt_q + 1'b1) : '0;
      end
   end

   AST_STREAK_STEP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1)); // R3
   AST_STREAK_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == SMAX && !clr_i && !(evt_end && !seen_q)) |=> (cnt_q == SMAX)); // R3

endmodule

// File: rtl/rptr_long_coll_timer.sv
// Measures the length of the current collision in clock cycles.
module rptr_long_coll_timer #(
   parameter int LONG_COLL_CYC = 71900
) (
   input  logic clk,
   input  logic rst,
   input  logic coll_i,
   output logic trip_o
);
   localparam int TW = $clog2(LONG_COLL_CYC);
   localparam logic [TW-1:0] TLAST = TW'(LONG_COLL_CYC - 1);

   logic [TW-1:0] tmr_q;

   assign trip_o = coll_i & (tmr_q == TLAST);

   always_ff @(posedge clk) begin
      if (rst)
         tmr_q <= '0;
      else if (!coll_i)
         tmr_q <= '0;
      else if (tmr_q != TLAST)
         tmr_q <= tmr_q + 1'b1;
   end

   AST_TIMER_NEEDS_COLL: assert property (@(posedge clk) disable iff (rst)
      (tmr_q != '0) |-> $past(coll_i)); // R4

endmodule

// File: rtl/rptr_reconnect_window.sv
// Counts qualifying clean bit times while the port is isolated.
module rptr_reconnect_window #(
   parameter int RECON_BT = 500
) (
   input  logic clk,
   input  logic rst,
   input  logic part_i,
   input  logic qual_i,
   input  logic coll_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int WW = $clog2(RECON_BT);
   localparam logic [WW-1:0] WLAST = WW'(RECON_BT - 1);

   logic [WW-1:0] win_q;
   logic          advance;

   assign advance = part_i & qual_i & ~coll_i;
   assign done_o  = advance & tick_i & (win_q == WLAST);

   always_ff @(posedge clk) begin
      if (rst)
         win_q <= '0;
      else if (!advance)
         win_q <= '0;
      else if (tick_i)
         win_q <= done_o ? '0 : win_q + 1'b1;
   end

   AST_WIN_ABORT: assert property (@(posedge clk) disable iff (rst)
      coll_i |=> (win_q == '0)); // R8
   AST_WIN_ONLY_ISOLATED: assert property (@(posedge clk) disable iff (rst)
      (win_q != '0) |-> part_i); // R6

endmodule

// File: rtl/rptr_autopart.sv
module rptr_autopart #(
   parameter int COLL_LIMIT    = 60,
   parameter int LONG_COLL_CYC = 71900,
   parameter int RECON_BT      = 500,
   parameter int RECON_LO      = 450,
   parameter int RECON_HI      = 560
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_act,
   input  logic tx_act,
   input  logic coll,
   input  logic bit_tick,
   input  logic alt_sel,
   output logic part_o,
   output logic part_evt_o
);
   import rptr_part_pkg::*;

   generate
      if (COLL_LIMIT < 1) begin : g_bad_limit
         $error("COLL_LIMIT must be at least 1");
      end
      if (LONG_COLL_CYC < 2) begin : g_bad_long
         $error("LONG_COLL_CYC must be at least 2");
      end
      if (RECON_BT < 2 || RECON_BT < RECON_LO || RECON_BT > RECON_HI) begin : g_bad_recon
         $error("RECON_BT must lie within RECON_LO..RECON_HI and be at least 2");
      end
   endgenerate

   port_act_t   act;
   part_state_e state_q;
   logic        evt_q;
   logic        carrier;
   logic        qual;
   logic        trip_streak;
   logic        trip_long;
   logic        recon_done;
   logic        isolated;

   always_comb begin
      act.rx   = rx_act;
      act.tx   = tx_act;
      act.coll = coll;
   end

   assign carrier  = act.rx | act.tx | act.coll;
   assign qual     = alt_sel ? act.tx : (act.rx | act.tx);
   assign isolated = (state_q == PS_ISOLATED);

   rptr_coll_streak #(.COLL_LIMIT(COLL_LIMIT)) i_streak (
      .clk       (clk),
      .rst       (rst),
      .carrier_i (carrier),
      .coll_i    (act.coll),
      .clr_i     (recon_done),
      .trip_o    (trip_streak)
   );

   rptr_long_coll_timer #(.LONG_COLL_CYC(LONG_COLL_CYC)) i_long (
      .clk    (clk),
      .rst    (rst),
      .coll_i (act.coll),
      .trip_o (trip_long)
   );

   rptr_reconnect_window #(.RECON_BT(RECON_BT)) i_window (
      .clk    (clk),
      .rst    (rst),
      .part_i (isolated),
      .qual_i (qual),
      .coll_i (act.coll),
      .tick_i (bit_tick),
      .done_o (recon_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_CONNECTED;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         case (state_q)
            PS_CONNECTED: if (trip_streak || trip_long) begin
               state_q <= PS_ISOLATED;
               evt_q   <= 1'b1;
            end
            PS_ISOLATED: if (recon_done)
               state_q <= PS_CONNECTED;
            default: state_q <= PS_CONNECTED;
         endcase
      end
   end

   assign part_o     = isolated;
   assign part_evt_o = evt_q;

   AST_EVT_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
      $rose(isolated) |-> evt_q); // R5
   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
      evt_q |=> !evt_q); // R5
   AST_EVT_ONLY_ENTRY: assert property (@(posedge clk) disable iff (rst)
      evt_q |-> (isolated && !$past(isolated))); // R5
   AST_ALT_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
      (isolated && alt_sel && !tx_act) |=> isolated); // R7

endmodule

// File: tb/test_rptr_autopart.sv
`timescale 1ns/1ps
module test_rptr_autopart;
   localparam int L    = 3;
   localparam int LONG = 12;
   localparam int BT   = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rx_act = 1'b0, tx_act = 1'b0, coll = 1'b0, bit_tick = 1'b1, alt_sel = 1'b0;
   logic part_o, part_evt_o;

   int tests = 0;
   int fails = 0;
   int evt_total = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rptr_autopart #(.COLL_LIMIT(L), .LONG_COLL_CYC(LONG), .RECON_BT(BT),
                   .RECON_LO(4), .RECON_HI(8)) i_rptr_autopart (
      .clk(clk), .rst(rst), .rx_act(rx_act), .tx_act(tx_act), .coll(coll),
      .bit_tick(bit_tick), .alt_sel(alt_sel), .part_o(part_o), .part_evt_o(part_evt_o)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic t, input logic c, input logic k);
      rx_act = r; tx_act = t; coll = c; bit_tick = k;
      @(posedge clk);
      @(negedge clk);
      if (part_evt_o) evt_total++;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) step(0, 0, 0, 1);
      rst = 1'b0;
      evt_total = 0;
   endtask

   task automatic coll_event();
      step(1, 0, 1, 1); step(1, 0, 1, 1); step(0, 0, 0, 1);
   endtask

   task automatic clean_event();
      step(1, 0, 0, 1); step(1, 0, 0, 1); step(0, 0, 0, 1);
   endtask

   task automatic go_part();
      repeat (LONG) step(1, 0, 1, 1);
      step(0, 0, 0, 1);
      check("R4 setup isolate", part_o, 1);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1
      check("R1 part after reset", part_o, 0);
      check("R1 evt after reset", part_evt_o, 0);

      // R2: sweep streak lengths
      for (int n = 1; n <= L + 1; n++) begin
         do_reset();
         for (int i = 1; i <= n; i++) begin
            coll_event();
            check("R2 streak", part_o, (i > L) ? 1 : 0);
         end
         if (n == L + 1) begin
            check("R5 entry pulse", part_evt_o, 1);
            step(0, 0, 0, 1);
            check("R5 pulse one cycle", part_evt_o, 0);
            check("R5 pulse count", evt_total, 1);
         end
      end

      // R3: clean event clears streak at each position
      for (int k = 1; k <= L; k++) begin
         do_reset();
         repeat (k) coll_event();
         clean_event();
         repeat (L) coll_event();
         check("R3 streak cleared", part_o, 0);
         coll_event();
         check("R3 fresh streak trips", part_o, 1);
      end

      // R4: long collision
      do_reset();
      repeat (LONG - 1) step(1, 0, 1, 1);
      step(0, 0, 0, 1);
      check("R4 short collision", part_o, 0);
      do_reset();
      repeat (LONG - 1) step(1, 0, 1, 1);
      check("R4 before limit", part_o, 0);
      step(1, 0, 1, 1);
      check("R4 at limit", part_o, 1);
      step(0, 0, 0, 1);

      // R5: no further pulses while isolated
      repeat (LONG + 5) step(1, 0, 1, 1);
      step(0, 0, 0, 1);
      repeat (L + 3) coll_event();
      check("R5 still isolated", part_o, 1);
      check("R5 no repeat pulse", evt_total, 1);

      // R6: default rule, rx only
      repeat (BT - 1) step(1, 0, 0, 1);
      check("R6 one tick short", part_o, 1);
      step(1, 0, 0, 1);
      check("R6 reconnect rx", part_o, 0);
      step(0, 0, 0, 1);
      check("R5 no pulse on exit", evt_total, 1);

      // R8: collision aborts window
      do_reset();
      go_part();
      repeat (BT - 1) step(1, 0, 0, 1);
      step(1, 0, 1, 1);
      repeat (BT - 1) step(1, 0, 0, 1);
      check("R8 collision restart", part_o, 1);
      step(1, 0, 0, 1);
      check("R8 reconnect after restart", part_o, 0);

      // R8: gap aborts window
      do_reset();
      go_part();
      repeat (BT - 1) step(1, 0, 0, 1);
      step(0, 0, 0, 1);
      repeat (BT - 1) step(1, 0, 0, 1);
      check("R8 gap restart", part_o, 1);
      step(1, 0, 0, 1);
      check("R8 reconnect after gap", part_o, 0);

      // R6: bit_tick gating, tick every third cycle
      do_reset();
      go_part();
      for (int s = 0; s < 3 * BT - 1; s++) step(1, 0, 0, (s % 3) == 2);
      check("R6 tick gating short", part_o, 1);
      step(1, 0, 0, 1);
      check("R6 tick gating reconnect", part_o, 0);

      // R6: tx only in default mode
      do_reset();
      go_part();
      repeat (BT) step(0, 1, 0, 1);
      check("R6 reconnect tx", part_o, 0);

      // R7: alternate rule
      do_reset();
      alt_sel = 1'b1;
      go_part();
      repeat (3 * BT) step(1, 0, 0, 1);
      check("R7 rx ignored", part_o, 1);
      step(0, 0, 0, 1);
      repeat (BT - 1) step(0, 1, 0, 1);
      check("R7 tx one short", part_o, 1);
      step(0, 1, 0, 1);
      check("R7 reconnect tx", part_o, 0);
      step(0, 0, 0, 1);
      alt_sel = 1'b0;

      // R9: streak cleared by reconnection
      do_reset();
      go_part();
      repeat (BT) step(1, 0, 0, 1);
      check("R9 reconnected", part_o, 0);
      step(1, 0, 1, 1);
      step(0, 0, 0, 1);
      check("R9 first event after reconnect", part_o, 0);
      repeat (L - 1) coll_event();
      check("R9 streak at limit", part_o, 0);
      coll_event();
      check("R9 streak trips again", part_o, 1);
      check("R5 second entry counted", evt_total, 2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule